// File: doc/BRIEF.md
# Coprocessor Run/Halt and Break Controller

This block decides whether a small in-order pipelined coprocessor runs or is held, and where its fetch restarts. Software changes a status word through a command register: each status flag has its own set bit and its own clear bit, so one write can change several flags without a read-modify-write. The same status word is also updated by a BREAK request from the execute stage. Both kinds of update pass through one merge-and-apply path, so each cycle applies exactly one atomic update.

The block drives three pipeline controls. A stall level holds every stage while the processor is halted. A one-cycle flush pulse clears the pipeline. A restart address goes with the flush pulse and loads the fetch stage.

A BREAK is committed at the clock edge that ends its execute cycle. The cycle after it is aborted, because stall is already high. During that aborted cycle the block samples the execute-stage PC, which is the instruction that would have run next. That PC is where execution resumes. For a BREAK in a branch delay slot, this is the branch target.

A write to the PC register is accepted only while the processor is halted. It flushes the pipeline on the next cycle and loads the masked, word-aligned address. A PC write while the processor is running is refused and flagged.

The controller is a four-state machine:
- RUN: stall follows HALT.
- HALTED: held; waiting for HALT to drop.
- PCLOAD: flush pulse with a PC written by software while halted.
- RESTART: flush pulse with the resume address, after HALT has been cleared.

Its transitions are:
- RUN to HALTED: HALT is set and stays set. The execute PC is captured.
- RUN to RESTART: HALT is set but is cleared in the same cycle. The execute PC is captured.
- RUN, HALTED or PCLOAD to PCLOAD: a PC write arrives while HALT is set.
- HALTED or PCLOAD to RESTART: the next value of HALT is clear.
- RESTART to RUN: always.

Reset enters HALTED.

Top module: `run_halt_ctrl`

## Requirements
- R1: After reset, stall_o is 1, flush_o is 0, irq_o is 0, pc_err_o is 0, the BROKE flag reads 0 and the PC register reads 0.
- R2: Status command bits are: clear-halt 0, set-halt 1, clear-broke 2, clear-irq 3, set-irq 4, clear-irq-on-break 7, set-irq-on-break 8. For each signal flag n (0 to 7), clear is at bit 9+2n and set is at bit 10+2n, so signal 6 is set by bit 22, and signal 7 is cleared by bit 23 and set by bit 24. A set bit alone sets its flag, a clear bit alone clears it, and both together leave the flag unchanged. The change is visible from the next cycle.
- R3: Bit 31 is an internal set-broke command. It is ignored on software writes, and when it meets a clear-broke bit in the same update, the clear wins.
- R4: A BREAK accepted in a cycle sets HALT and BROKE at that cycle's closing edge, so stall_o is 1 from the next cycle.
- R5: If the irq-on-break flag is set when a BREAK is accepted, irq_o rises in the next cycle. irq_o is otherwise driven only by the set-irq and clear-irq commands.
- R6: When the processor stops from the running state, the resume address is the ex_pc_i value present in the first stalled cycle. For a BREAK in a delay slot, that is the branch target.
- R7: When HALT drops, the next cycle shows flush_o = 1 and stall_o = 0, with restart_pc_o equal to the resume address. flush_o is 0 in the cycle after that.
- R8: A PC write while halted sets restart_pc_o to wr_data_i with bits 11:2 kept and all other bits zero. flush_o pulses in the next cycle while stall_o stays 1.
- R9: A PC write while running leaves the PC unchanged and raises pc_err_o for one cycle, in the next cycle.
- R10: A BREAK and a software status write in the same cycle are merged into one update. Each flag follows the rules of R2 and R3 over the combined command bits.
- R11: brk_i is ignored while stall_o or flush_o is high.
- R12: Reading with rd_sel_i = 0 returns HALT in bit 0, BROKE in bit 1, irq-on-break in bit 2 and signal flags 0 to 7 in bits 10:3, with zeros above. Reading with rd_sel_i = 1 returns the PC in bits 11:0, with zeros above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | Write target: 0 status command, 1 PC |
| wr_data_i | input | 32 | Write data |
| rd_sel_i | input | 1 | Read target: 0 status, 1 PC |
| rd_data_o | output | 32 | Read data, combinational |
| brk_i | input | 1 | BREAK request from the execute stage |
| ex_pc_i | input | 12 | Execute-stage PC |
| irq_o | output | 1 | Coprocessor interrupt |
| stall_o | output | 1 | Hold all pipeline stages |
| flush_o | output | 1 | One-cycle pipeline flush |
| restart_pc_o | output | 12 | Fetch restart address, valid with flush_o |
| pc_err_o | output | 1 | PC written while running |

## Verification
The collision of interest is a BREAK and a software status write in the same cycle. Both feed the single update path, and R10 and R3 decide the outcome.

The bench provokes this by raising brk_i while a command write is presented, in several ways:
- together with clear-broke;
- together with set-irq and signal commands;
- together with a clear-halt that cancels the break's halt.

In each case the bench model merges the command bits on its own and compares every flag, stall_o and the later flush on each clock.

// File: rtl/rhc_pkg.sv
package rhc_pkg;
    localparam int PC_W    = 12;
    localparam int DATA_W  = 32;
    localparam int NUM_SIG = 8;
    localparam int STAT_W  = 3 + NUM_SIG;

    localparam int B_CLR_HALT   = 0;
    localparam int B_SET_HALT   = 1;
    localparam int B_CLR_BROKE  = 2;
    localparam int B_CLR_IRQ    = 3;
    localparam int B_SET_IRQ    = 4;
    localparam int B_CLR_IBRK   = 7;
    localparam int B_SET_IBRK   = 8;
    localparam int B_SIG_BASE   = 9;
    localparam int B_SET_BROKE  = DATA_W - 1;

    typedef enum logic [1:0] {
        ST_RUN     = 2'd0,
        ST_HALTED  = 2'd1,
        ST_PCLOAD  = 2'd2,
        ST_RESTART = 2'd3
    } ctl_state_t;

    function automatic logic [PC_W-1:0] align_pc(input logic [DATA_W-1:0] d);
        align_pc = {d[PC_W-1:2], 2'b00};
    endfunction

    function automatic logic pair_upd(input logic cur, input logic s, input logic c);
        pair_upd = (s ^ c) ? s : cur;
    endfunction
endpackage

// File: rtl/rhc_status.sv
module rhc_status
    import rhc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_wr_i,
    input  logic [DATA_W-1:0] sw_cmd_i,
    input  logic              brk_go_i,
    output logic              halt_q_o,
    output logic              halt_d_o,
    output logic [STAT_W-1:0] status_o,
    output logic              irq_o
);
    logic [DATA_W-1:0] cmd;
    logic [DATA_W-1:0] brk_cmd;
    logic              halt_q, broke_q, ibrk_q, irq_q;
    logic              broke_d, ibrk_d, irq_d;
    logic [NUM_SIG-1:0] sig_q, sig_d;

    always_comb begin
        brk_cmd = '0;
        if (brk_go_i) begin
            brk_cmd[B_SET_HALT]  = 1'b1;
            brk_cmd[B_SET_BROKE] = 1'b1;
            brk_cmd[B_SET_IRQ]   = ibrk_q;
        end
        cmd = (sw_wr_i ? {1'b0, sw_cmd_i[DATA_W-2:0]} : '0) | brk_cmd;
    end

    always_comb begin
        halt_d_o = pair_upd(halt_q, cmd[B_SET_HALT], cmd[B_CLR_HALT]);
        irq_d    = pair_upd(irq_q, cmd[B_SET_IRQ], cmd[B_CLR_IRQ]);
        ibrk_d   = pair_upd(ibrk_q, cmd[B_SET_IBRK], cmd[B_CLR_IBRK]);
        if (cmd[B_CLR_BROKE])
            broke_d = 1'b0;
        else if (cmd[B_SET_BROKE])
            broke_d = 1'b1;
        else
            broke_d = broke_q;
    end

    for (genvar n = 0; n < NUM_SIG; n++) begin : g_sig
        assign sig_d[n] = pair_upd(sig_q[n], cmd[B_SIG_BASE+2*n+1], cmd[B_SIG_BASE+2*n]);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            halt_q  <= 1'b1;
            broke_q <= 1'b0;
            ibrk_q  <= 1'b0;
            irq_q   <= 1'b0;
            sig_q   <= '0;
        end else begin
            halt_q  <= halt_d_o;
            broke_q <= broke_d;
            ibrk_q  <= ibrk_d;
            irq_q   <= irq_d;
            sig_q   <= sig_d;
        end
    end

    assign halt_q_o = halt_q;
    assign irq_o    = irq_q;
    assign status_o = {sig_q, ibrk_q, broke_q, halt_q};

    AST_BRK_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
        (brk_go_i && !(sw_wr_i && sw_cmd_i[B_CLR_HALT])) |=> halt_q); // R4
    AST_SW_NO_SETBROKE: assert property (@(posedge clk) disable iff (!rst_n)
        (!brk_go_i && !broke_q) |=> !broke_q); // R3
    AST_CLRBROKE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_wr_i && sw_cmd_i[B_CLR_BROKE]) |=> !broke_q); // R3
    AST_BRK_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (brk_go_i && ibrk_q && !(sw_wr_i && sw_cmd_i[B_CLR_IRQ])) |=> irq_q); // R5
endmodule

// File: rtl/rhc_fsm.sv
module rhc_fsm
    import rhc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              halt_q_i,
    input  logic              halt_d_i,
    input  logic              pc_wr_i,
    input  logic [DATA_W-1:0] pc_data_i,
    input  logic [PC_W-1:0]   ex_pc_i,
    output logic              brk_ok_o,
    output logic              flush_o,
    output logic [PC_W-1:0]   pc_o,
    output logic              pc_err_o
);
    ctl_state_t state_q, state_d;
    logic [PC_W-1:0] pc_q, pc_d;
    logic            err_q;

    always_comb begin
        state_d = state_q;
        pc_d    = pc_q;
        if (halt_q_i && pc_wr_i) begin
            state_d = ST_PCLOAD;
            pc_d    = align_pc(pc_data_i);
        end else begin
            unique case (state_q)
                ST_RUN: if (halt_q_i) begin
                    pc_d    = ex_pc_i;
                    state_d = halt_d_i ? ST_HALTED : ST_RESTART;
                end
                ST_HALTED, ST_PCLOAD:
                    state_d = halt_d_i ? ST_HALTED : ST_RESTART;
                ST_RESTART:
                    state_d = ST_RUN;
                default:
                    state_d = ST_HALTED;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_HALTED;
            pc_q    <= '0;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            pc_q    <= pc_d;
            err_q   <= pc_wr_i && !halt_q_i;
        end
    end

    always_comb begin
        flush_o  = 1'b0;
        brk_ok_o = 1'b0;
        unique case (state_q)
            ST_RUN:     brk_ok_o = !halt_q_i;
            ST_HALTED:  flush_o  = 1'b0;
            ST_PCLOAD:  flush_o  = 1'b1;
            ST_RESTART: flush_o  = 1'b1;
            default:    flush_o  = 1'b0;
        endcase
    end

    assign pc_o     = pc_q;
    assign pc_err_o = err_q;

    AST_FLUSH_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_o && !halt_q_i) |=> !flush_o); // R7
    AST_PC_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        pc_o[1:0] == 2'b00); // R8
    AST_ERR_RUNNING: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_wr_i && !halt_q_i) |=> (pc_err_o && $stable(pc_o))); // R9
    AST_NO_BRK_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
        (halt_q_i || flush_o) |-> !brk_ok_o); // R11
endmodule

// File: rtl/run_halt_ctrl.sv
module run_halt_ctrl
    import rhc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic              wr_sel_i,
    input  logic [31:0]       wr_data_i,
    input  logic              rd_sel_i,
    output logic [31:0]       rd_data_o,
    input  logic              brk_i,
    input  logic [11:0]       ex_pc_i,
    output logic              irq_o,
    output logic              stall_o,
    output logic              flush_o,
    output logic [11:0]       restart_pc_o,
    output logic              pc_err_o
);
    logic              halt_q, halt_d, brk_ok;
    logic [STAT_W-1:0] status;
    logic [PC_W-1:0]   pc;

    rhc_status u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .sw_wr_i  (wr_en_i && !wr_sel_i),
        .sw_cmd_i (wr_data_i),
        .brk_go_i (brk_i && brk_ok),
        .halt_q_o (halt_q),
        .halt_d_o (halt_d),
        .status_o (status),
        .irq_o    (irq_o)
    );

    rhc_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .halt_q_i  (halt_q),
        .halt_d_i  (halt_d),
        .pc_wr_i   (wr_en_i && wr_sel_i),
        .pc_data_i (wr_data_i),
        .ex_pc_i   (ex_pc_i),
        .brk_ok_o  (brk_ok),
        .flush_o   (flush_o),
        .pc_o      (pc),
        .pc_err_o  (pc_err_o)
    );

    assign stall_o      = halt_q;
    assign restart_pc_o = pc;
    assign rd_data_o    = rd_sel_i ? {{(DATA_W-PC_W){1'b0}}, pc}
                                   : {{(DATA_W-STAT_W){1'b0}}, status};
endmodule

// File: tb/run_halt_ctrl_tb_top.sv
module run_halt_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, wr_sel = 1'b0, rd_sel = 1'b0, brk = 1'b0;
    logic [31:0] wr_data = '0;
    logic [11:0] ex_pc = '0;
    logic [31:0] rd_data;
    logic        irq, stall, flush, pc_err;
    logic [11:0] rpc;

    int n_vec = 0, n_bad = 0;
    bit done = 0;
    string tag = "R1";

    // behavioural reference state
    int m_ph;   // 0 run, 1 held, 2 pc-load flush, 3 restart flush
    bit m_halt, m_broke, m_ibrk, m_irq, m_err;
    bit [7:0] m_sig;
    int m_pc;

    always #(CLK_PERIOD/2) clk = ~clk;

    run_halt_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
        .wr_data_i(wr_data), .rd_sel_i(rd_sel), .rd_data_o(rd_data),
        .brk_i(brk), .ex_pc_i(ex_pc), .irq_o(irq), .stall_o(stall),
        .flush_o(flush), .restart_pc_o(rpc), .pc_err_o(pc_err)
    );

    function automatic bit pr(bit cur, bit s, bit c);
        return (s != c) ? s : cur;
    endfunction

    task automatic chk(string what, longint act, longint exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic compare();
        longint st;
        st = {m_sig, m_ibrk, m_broke, m_halt};
        chk("stall_o (R4)", stall, m_halt);
        chk("flush_o (R7 R8)", flush, (m_ph == 2 || m_ph == 3));
        chk("restart_pc_o (R6 R8)", rpc, m_pc);
        chk("irq_o (R5)", irq, m_irq);
        chk("pc_err_o (R9)", pc_err, m_err);
        chk("rd_data_o (R12)", rd_data, rd_sel ? m_pc : st);
    endtask

    // one clock: compare present outputs, apply inputs, advance the model
    task automatic cyc(bit we, bit sel, logic [31:0] d, bit b, logic [11:0] xp);
        bit [31:0] cmd;
        bit acc, nh, pcw;
        wr_en = we; wr_sel = sel; wr_data = d; brk = b; ex_pc = xp;
        rd_sel = ~rd_sel;
        #1;
        compare();
        cmd = (we && !sel) ? (d & 32'h7fff_ffff) : 32'h0;
        acc = (m_ph == 0) && !m_halt;
        if (acc && b) cmd = cmd | 32'h8000_0002 | (m_ibrk ? 32'h10 : 32'h0);
        nh  = pr(m_halt, cmd[1], cmd[0]);
        pcw = we && sel;
        @(posedge clk);
        m_err = pcw && !m_halt;
        if (m_halt && pcw) begin
            m_pc = int'(d & 32'hffc); m_ph = 2;
        end else if (m_ph == 0) begin
            if (m_halt) begin m_pc = int'(xp); m_ph = nh ? 1 : 3; end
        end else if (m_ph == 3) m_ph = 0;
        else m_ph = nh ? 1 : 3;
        m_halt = nh;
        m_broke = cmd[2] ? 1'b0 : (cmd[31] ? 1'b1 : m_broke);
        m_irq  = pr(m_irq, cmd[4], cmd[3]);
        m_ibrk = pr(m_ibrk, cmd[8], cmd[7]);
        for (int n = 0; n < 8; n++) m_sig[n] = pr(m_sig[n], cmd[10+2*n], cmd[9+2*n]);
        @(negedge clk);
    endtask

    task automatic idle(int n, logic [11:0] xp);
        for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, xp + 12'(4*i));
    endtask

    task automatic cmdw(logic [31:0] d);
        cyc(1, 0, d, 0, 12'h0);
    endtask

    initial begin
        m_ph = 1; m_halt = 1; m_broke = 0; m_ibrk = 0; m_irq = 0; m_err = 0; m_sig = 0; m_pc = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        tag = "R1"; idle(2, 12'h040);                      // reset state, held
        tag = "R2";                                        // sig6 set b22, sig7 b23/b24
        cmdw(32'h0040_0000); cmdw(32'h0180_0000); cmdw(32'h0100_0000);
        cmdw(32'h0180_0000); cmdw(32'h0080_0000); cmdw(32'h0000_0003);
        tag = "R3"; cmdw(32'h8000_0000);                    // bit31 from software ignored
        tag = "R2"; cmdw(32'h0000_0100);                    // irq-on-break on
        tag = "R7"; cmdw(32'h0000_0001); idle(4, 12'h100);  // resume from pc 0
        tag = "R4"; cyc(0, 0, 0, 1, 12'h110);               // break
        tag = "R6"; cyc(0, 0, 0, 1, 12'h204);               // delay slot target, R11 brk ignored
        tag = "R11"; cyc(0, 0, 0, 1, 12'h208); idle(2, 12'h300);
        tag = "R8"; cyc(1, 1, 32'h1234_5677, 0, 12'h0); idle(2, 12'h0);
        tag = "R5"; cmdw(32'h0000_000c);                    // clear broke and irq
        tag = "R7"; cmdw(32'h0000_0001);
        tag = "R11"; cyc(0, 0, 0, 1, 12'h500);              // break during restart flush
        tag = "R9"; cyc(1, 1, 32'h0000_0abc, 0, 12'h504); idle(2, 12'h508);
        tag = "R3"; cmdw(32'h8000_0000); idle(1, 12'h600);
        tag = "R10"; cyc(1, 0, 32'h0000_0004, 1, 12'h610);  // break + clear-broke
        cyc(0, 0, 0, 0, 12'h614); idle(2, 12'h0);
        tag = "R7"; cmdw(32'h0000_0001); idle(2, 12'h700);
        tag = "R10"; cyc(1, 0, 32'h0040_0090, 1, 12'h720);  // break + irq/sig cmds
        cyc(0, 0, 0, 0, 12'h724);
        tag = "R7"; cmdw(32'h0000_0001); idle(2, 12'h800);
        tag = "R10"; cyc(1, 0, 32'h0000_0001, 1, 12'h820);  // break + clear-halt: stays running
        idle(3, 12'h824);
        tag = "R2"; cmdw(32'h0000_0002);                     // sw halt while running
        tag = "R6"; cyc(0, 0, 0, 0, 12'h9a0);
        tag = "R7"; cyc(1, 0, 32'h0000_0001, 0, 12'h9a4);    // clear in capture cycle
        idle(2, 12'ha00);
        tag = "R2"; cmdw(32'h0000_0002); idle(1, 12'h0);
        cmdw(32'h0000_0003); idle(2, 12'h0);                 // set+clear halt keeps halted
        tag = "R8"; cyc(1, 1, 32'hffff_ffff, 0, 12'h0);
        cmdw(32'h0000_0001); idle(3, 12'hb00);
        tag = "R12"; idle(2, 12'hc00);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule